// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block takes a stream of decimal digits in 8421 code, one bit per clock with the least significant bit of each digit first, and sends back the same digits in Excess-3 code in the same bit order. Each output digit is the input digit plus three. The conversion is done by a serial adder: a bit-position counter picks the bit of the constant three that belongs to the current bit, and a one-bit carry register links the four bits of a digit together.

The converter is a Moore machine. The output bit is a stored state bit and never a gate path from the input. The result for an input bit appears during the clock period that follows the edge where that bit was taken in. Digits follow each other with no gap. After every fourth bit the carry is dropped and the counter wraps, so the next bit is taken as bit 0 of a new digit. A pulse output marks the clock period in which bit 0 of each converted digit is shown. Input codes 10 to 15 use the same add-three rule modulo 16 and raise no flag.

Top module: `bcdx3_converter`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `z_out` and `digit_first` to 0 and makes the next edge take bit 0 of a new digit.
- R2: The bit taken from `x_in` at one rising edge decides `z_out` from that edge until the next, so the output lags the input by exactly one clock.
- R3: A digit of value v, sent as bits b0,b1,b2,b3 (b0 first, v = b0 + 2*b1 + 4*b2 + 8*b3), comes out as the four bits of v+3 in the same order, b0 first. For example, input bits 0,0,1,0,1,0,0,1 produce output bits 1,1,1,0,0,0,1,1.
- R4: Digits follow each other with no idle cycles. A carry from one digit never reaches the next: 9 followed by 0 gives 12 followed by 3.
- R5: Input codes 10 to 15 give (v+3) mod 16 with no error indication: 13 gives 0 and 15 gives 2.
- R6: `digit_first` is 1 exactly in the clock periods when `z_out` shows bit 0 of a digit, that is, every fourth period starting with the first period after reset is released. It is 0 in all other periods.
- R7: A change on `x_in` between rising edges has no effect on `z_out` before the next rising edge.
- R8: A reset that is applied in the middle of a digit drops the partial digit. The first bit after the reset is released is taken as bit 0 of a new digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge takes one input bit |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial 8421 digit bits, least significant bit first |
| z_out | output | 1 | Serial Excess-3 bits, least significant bit first |
| digit_first | output | 1 | High while z_out shows bit 0 of a digit |

## Verification
If the bit counter is wrong, the framing slips. This shows at the ports within four clocks: `digit_first` falls out of its every-fourth-period rhythm, and the constant three is added at the wrong bit positions. If the carry register is wrong, the damage stays inside one digit. It shows in the first output bit after the faulty carry and is cleared by the end of that digit. A carry that leaks across the digit boundary shows in bit 0 of the next digit, which should then be the plain inverse of the input bit. A path from the input straight to the output shows up as a change on `z_out` between clock edges when `x_in` changes.

// File: rtl/bcdx3_pkg.sv
package bcdx3_pkg;

    // One-bit full-adder result
    typedef struct packed {
        logic cout;
        logic sum;
    } fa_t;

    function automatic fa_t full_add(input logic a, input logic b, input logic c);
        fa_t r;
        r.sum  = a ^ b ^ c;
        r.cout = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/bcdx3_bit_slot.sv
// Bit-position counter inside a digit, plus a registered bit-0 marker.
module bcdx3_bit_slot #(
    parameter int DIGIT_W = 4,
    localparam int POS_W  = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos_q,
    output logic             last_bit,
    output logic             first_q
);
    localparam logic [POS_W-1:0] LAST = POS_W'(DIGIT_W - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             first;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pos   = (s_q.pos == LAST) ? '0 : s_q.pos + 1'b1;
        s_d.first = (s_q.pos == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_q    = s_q.pos;
    assign last_bit = (s_q.pos == LAST);
    assign first_q  = s_q.first;
endmodule

// File: rtl/bcdx3_bias_sel.sv
// Picks the bit of the constant addend that belongs to the current position.
module bcdx3_bias_sel #(
    parameter int                 DIGIT_W = 4,
    parameter logic [DIGIT_W-1:0] BIAS    = 3,
    localparam int                POS_W   = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
    input  logic [POS_W-1:0] pos,
    output logic             bias_bit
);
    assign bias_bit = BIAS[pos];
endmodule

// File: rtl/bcdx3_serial_adder.sv
// Serial adder: the output bit and the carry are both Moore state.
module bcdx3_serial_adder
    import bcdx3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_bit,
    input  logic bias_bit,
    input  logic last_bit,
    output logic z_q,
    output logic carry_q
);
    typedef struct packed {
        logic carry;
        logic z;
    } add_t;

    add_t a_d, a_q;
    fa_t  fa;

    always_comb begin
        fa        = full_add(x_bit, bias_bit, a_q.carry);
        a_d.z     = fa.sum;
        // drop the carry out of the top bit: modulo-2^DIGIT_W result
        a_d.carry = last_bit ? 1'b0 : fa.cout;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign z_q     = a_q.z;
    assign carry_q = a_q.carry;
endmodule

// File: rtl/bcdx3_converter.sv
module bcdx3_converter #(
    parameter int                 DIGIT_W = 4,
    parameter logic [DIGIT_W-1:0] BIAS    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out,
    output logic digit_first
);
    localparam int POS_W = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1;

    logic [POS_W-1:0] pos_q;
    logic             last_bit;
    logic             bias_bit;
    logic             carry_q;

    bcdx3_bit_slot #(.DIGIT_W(DIGIT_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .pos_q    (pos_q),
        .last_bit (last_bit),
        .first_q  (digit_first)
    );

    bcdx3_bias_sel #(.DIGIT_W(DIGIT_W), .BIAS(BIAS)) u_bias (
        .pos      (pos_q),
        .bias_bit (bias_bit)
    );

    bcdx3_serial_adder u_add (
        .clk      (clk),
        .rst      (rst),
        .x_bit    (x_in),
        .bias_bit (bias_bit),
        .last_bit (last_bit),
        .z_q      (z_out),
        .carry_q  (carry_q)
    );
endmodule

// File: rtl/bcdx3_checker.sv
module bcdx3_checker #(
    parameter int                 DIGIT_W = 4,
    parameter logic [DIGIT_W-1:0] BIAS    = 3,
    localparam int                POS_W   = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             x_in,
    input logic             z_out,
    input logic             digit_first,
    input logic [POS_W-1:0] pos_q,
    input logic             carry_q
);
    localparam logic [POS_W-1:0] CHK_LAST = POS_W'(DIGIT_W - 1);

    // Independent count of bits taken in since reset, modulo digit width
    logic [POS_W-1:0] chk_phase;
    always_ff @(posedge clk) begin
        if (rst) chk_phase <= '0;
        else     chk_phase <= (chk_phase == CHK_LAST) ? '0 : chk_phase + 1'b1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!z_out && !digit_first));

    assert_bit0_no_carry_in_R3: assert property (@(posedge clk) disable iff (rst)
        digit_first |-> (z_out == ($past(x_in) ^ BIAS[0])));

    assert_carry_clear_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        (pos_q == '0) |-> !carry_q);

    assert_marker_rhythm_R6: assert property (@(posedge clk) disable iff (rst)
        digit_first == (chk_phase == POS_W'(1 % DIGIT_W)));

    assert_framing_restart_R8: assert property (@(posedge clk) disable iff (rst)
        pos_q == chk_phase);
endmodule

bind bcdx3_converter bcdx3_checker #(.DIGIT_W(DIGIT_W), .BIAS(BIAS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .x_in        (x_in),
    .z_out       (z_out),
    .digit_first (digit_first),
    .pos_q       (pos_q),
    .carry_q     (carry_q)
);

// File: tb/bcdx3_converter_bench.sv
module bcdx3_converter_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out, digit_first;

    int checks = 0;
    int errors = 0;

    logic xs [0:127];
    logic ez [0:127];
    int   n = 0;

    always #2 clk = ~clk;   // 250 MHz

    bcdx3_converter u_bcdx3_converter (
        .clk(clk), .rst(rst), .x_in(x_in), .z_out(z_out), .digit_first(digit_first)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic clear_stream();
        n = 0;
    endtask

    task automatic push_digit(input int v);
        int e;
        e = (v + 3) % 16;
        for (int b = 0; b < 4; b++) begin
            xs[n] = 1'((v >> b) & 1);
            ez[n] = 1'((e >> b) & 1);
            n++;
        end
    endtask

    // Starts at a falling edge with reset released; drives one bit per cycle,
    // checks each result at the falling edge after the sampling edge.
    task automatic play(input string req, input bit glitch, input int limit);
        logic zsnap;
        for (int i = 0; i < limit; i++) begin
            if (glitch) begin
                zsnap = z_out;
                x_in  = ~xs[i];
                #1;
                check("R7", "z moved with x between edges", z_out, zsnap);
            end
            x_in = xs[i];
            @(negedge clk);
            check(req, $sformatf("z bit %0d", i), z_out, ez[i]);
            check("R6", $sformatf("digit_first at bit %0d", i), digit_first, ((i % 4) == 0));
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        x_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "z during reset", z_out, 1'b0);
        check("R1", "digit_first during reset", digit_first, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        do_reset();
    endtask

    task automatic t_example_sequence();
        logic xin [0:7];
        logic zex [0:7];
        xin = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        zex = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
        do_reset();
        clear_stream();
        for (int i = 0; i < 8; i++) begin
            xs[i] = xin[i];
            ez[i] = zex[i];
        end
        n = 8;
        play("R2", 1'b0, n);
    endtask

    task automatic t_all_digits();
        do_reset();
        clear_stream();
        for (int v = 0; v < 10; v++) push_digit(v);
        play("R3", 1'b0, n);
    endtask

    task automatic t_carry_boundary();
        do_reset();
        clear_stream();
        push_digit(9); push_digit(0); push_digit(9); push_digit(0); push_digit(8);
        play("R4", 1'b0, n);
    endtask

    task automatic t_invalid_codes();
        do_reset();
        clear_stream();
        for (int v = 10; v < 16; v++) push_digit(v);
        play("R5", 1'b0, n);
    endtask

    task automatic t_moore_isolation();
        do_reset();
        clear_stream();
        push_digit(5); push_digit(2); push_digit(7);
        play("R7", 1'b1, n);
    endtask

    task automatic t_mid_digit_reset();
        do_reset();
        clear_stream();
        push_digit(6);
        play("R8", 1'b0, 2);
        rst  = 1'b1;
        x_in = 1'b1;
        @(negedge clk);
        check("R8", "z after mid-digit reset", z_out, 1'b0);
        check("R8", "digit_first after mid-digit reset", digit_first, 1'b0);
        rst = 1'b0;
        clear_stream();
        push_digit(2); push_digit(7); push_digit(11);
        play("R8", 1'b0, n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: all requirements actual=hung expected=finished");
        report();
    end

    initial begin
        t_reset_state();
        t_example_sequence();
        t_all_digits();
        t_carry_boundary();
        t_invalid_codes();
        t_moore_isolation();
        t_mid_digit_reset();
        report();
    end
endmodule